// File: doc/BRIEF.md
# AC-link Output Frame Serializer

This block builds the outgoing frame of an AC97-style audio link and shifts it out one bit per bit clock. Each frame starts with a 16-bit tag word and is followed by twelve 20-bit slots. The tag word holds the frame-valid flag, one valid flag per slot and the codec ID. The serializer runs from the bit clock that the codec supplies. It drives the serial data line and an active-high frame sync that rises one bit early and covers the whole tag word.

Two sources feed each frame. The first is a stereo pair of 16-bit PCM samples, placed in slots 3 and 4 while playback is enabled. The second is one pending control-register command: a read or write flag, a 7-bit register index and 16-bit write data, carried in slots 1 and 2. The command is put into the first frame that has not yet begun loading, and it is sent in that frame only. A one-cycle pulse marks the end of that frame, so the matching receiver can wait for the reply. New commands are refused until the receiver reports that the reply has arrived.

Top module: `aclink_tx_serializer`

## Requirements
- R1: A frame is 256 bit clocks long: a 16-bit tag word followed by twelve 20-bit slots. Every word goes out most significant bit first, and frames follow each other with no gap.
- R2: `sync` is high for exactly 16 bit clocks per frame. It rises in the cycle in which the last bit of the previous frame is on `sdata`, so it covers that bit and tag bits 15 to 1.
- R3: Tag bit 15 is set when playback is enabled or a command is in the frame. Bits 14, 13, 12 and 11 flag slots 1, 2, 3 and 4 as valid. Bits 10 to 2 are zero. Bits 1:0 carry `codec_id`.
- R4: Slot 1 holds the read flag in bit 19 (1 = read), the register index in bits 18:12, and zeros in bits 11:0. With no command in the frame the slot is all zero and its flag is clear.
- R5: Slot 2 holds the write data in bits 19:4 with zeros in bits 3:0, and its flag is set, only when the frame carries a write command. Otherwise the slot is zero.
- R6: Slots 3 and 4 hold `pcm_left` and `pcm_right` in bits 19:4 with zeros in bits 3:0, and both flags are set, only while `play_en` is high. When playback is idle both slots are zero. `play_en`, the samples and `codec_id` are sampled at the cycle the frame's first bit goes out.
- R7: Slots 5 to 12 are always zero and their tag flags are always clear.
- R8: A command is accepted in a cycle where `cmd_valid` is high and `cmd_busy` is low. It is placed in the next frame whose first bit is driven after acceptance, and it appears in no later frame.
- R9: `cmd_sent` is a one-cycle pulse. It is high in the cycle in which the last bit of the frame that carried the command is on `sdata`, and in no other cycle.
- R10: `cmd_busy` goes high when a command is accepted. It stays high until a `rsp_done` pulse that arrives after `cmd_sent`; an earlier `rsp_done` is ignored. `cmd_valid` has no effect while `cmd_busy` is high.
- R11: While `rst` is high, `sdata`, `sync`, `cmd_busy` and `cmd_sent` are low. On the first clock after reset `sync` rises, and the first frame begins on the clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the codec; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| codec_id | input | ID_W | Codec ID placed in tag bits 1:0 |
| play_en | input | 1 | Playback active; enables PCM slots and their flags |
| pcm_left | input | PCM_W | Left sample, goes to slot 3 |
| pcm_right | input | PCM_W | Right sample, goes to slot 4 |
| cmd_valid | input | 1 | Command request strobe |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| cmd_index | input | IDX_W | Register index |
| cmd_wdata | input | DATA_W | Write data |
| rsp_done | input | 1 | Receiver has taken the reply; releases `cmd_busy` |
| cmd_busy | output | 1 | A command is pending, in flight or awaiting its reply |
| cmd_sent | output | 1 | Pulse on the last bit of the frame that carried the command |
| sdata | output | 1 | Serial frame data |
| sync | output | 1 | Active-high frame sync |

## Verification
The bench builds the block with its default parameters: a 16-bit tag, twelve 20-bit slots, a 7-bit index and 16-bit data and samples. Each captured frame is therefore the full 256-bit frame, so one comparison covers every slot boundary and both pad nibbles. The vector table combines playback on and off with no command, a read and a write, and uses all-ones and single-bit samples and indices to catch slot misplacement. Directed cases cover a command appearing in exactly one frame, a command refused while busy, an early `rsp_done` being ignored, and reset applied in the middle of a frame.

// File: rtl/aclink_tx_pkg.sv
package aclink_tx_pkg;

  // Life cycle of one control command on the outgoing link.
  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,  // nothing held, new request may be taken
    CMD_PEND = 2'd1,  // held, waiting for the next frame load
    CMD_SEND = 2'd2,  // inside the frame currently shifting
    CMD_WAIT = 2'd3   // sent, waiting for the receiver's reply
  } cmd_state_e;

endpackage

// File: rtl/aclink_bit_timer.sv
// Bit position counter of the outgoing frame and early frame sync.
module aclink_bit_timer #(
  parameter int FRAME_LEN = 256,
  parameter int SYNC_W    = 16
) (
  input  logic clk,
  input  logic rst,
  output logic load,      // this edge drives the first bit of a new frame
  output logic last,      // this edge drives the last bit of the frame
  output logic sync_nxt   // sync level to register on this edge
);

  localparam int PW = $clog2(FRAME_LEN);
  localparam logic [PW-1:0] LAST_POS = PW'(FRAME_LEN - 1);
  localparam logic [PW-1:0] SYNC_END = PW'(SYNC_W - 1);

  logic [PW-1:0] pos_q;

  // Reset lands on the last position so the first edge raises sync
  // one bit ahead of the first frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= LAST_POS;
    end else if (pos_q == LAST_POS) begin
      pos_q <= '0;
    end else begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign load     = (pos_q == '0);
  assign last     = (pos_q == LAST_POS);
  assign sync_nxt = last || (pos_q < SYNC_END);

endmodule

// File: rtl/aclink_cmd_tracker.sv
// Holds one control command from acceptance until its reply arrives.
module aclink_cmd_tracker
  import aclink_tx_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              rsp_done,
  input  logic              load,
  input  logic              last,
  output logic              cmd_on,     // command goes into the frame being loaded
  output logic              hold_read,
  output logic [IDX_W-1:0]  hold_index,
  output logic [DATA_W-1:0] hold_wdata,
  output logic              busy,
  output logic              sent
);

  cmd_state_e        state_q;
  logic              sent_q;
  logic              read_q;
  logic [IDX_W-1:0]  index_q;
  logic [DATA_W-1:0] wdata_q;
  logic              take;

  assign take = cmd_valid && (state_q == CMD_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CMD_IDLE;
      sent_q  <= 1'b0;
    end else begin
      sent_q <= 1'b0;
      unique case (state_q)
        CMD_IDLE: if (cmd_valid) state_q <= CMD_PEND;
        CMD_PEND: if (load)      state_q <= CMD_SEND;
        CMD_SEND: if (last) begin
          state_q <= CMD_WAIT;
          sent_q  <= 1'b1;
        end
        CMD_WAIT: if (rsp_done)  state_q <= CMD_IDLE;
        default:                 state_q <= CMD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      read_q  <= 1'b0;
      index_q <= '0;
      wdata_q <= '0;
    end else if (take) begin
      read_q  <= cmd_read;
      index_q <= cmd_index;
      wdata_q <= cmd_wdata;
    end
  end

  assign cmd_on     = (state_q == CMD_PEND);
  assign hold_read  = read_q;
  assign hold_index = index_q;
  assign hold_wdata = wdata_q;
  assign busy       = (state_q != CMD_IDLE);
  assign sent       = sent_q;

endmodule

// File: rtl/aclink_frame_builder.sv
// Combinational assembly of one outgoing frame: tag word plus slots.
module aclink_frame_builder #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int IDX_W     = 7,
  parameter int DATA_W    = 16,
  parameter int PCM_W     = 16,
  parameter int ID_W      = 2
) (
  input  logic                                  cmd_on,
  input  logic                                  cmd_read,
  input  logic [IDX_W-1:0]                      cmd_index,
  input  logic [DATA_W-1:0]                     cmd_wdata,
  input  logic                                  play,
  input  logic [PCM_W-1:0]                      left,
  input  logic [PCM_W-1:0]                      right,
  input  logic [ID_W-1:0]                       codec_id,
  output logic [TAG_W+NUM_SLOTS*SLOT_W-1:0]     frame
);

  localparam int FRAME_LEN = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int CMD_PAD   = SLOT_W - 1 - IDX_W;
  localparam int DATA_PAD  = SLOT_W - DATA_W;
  localparam int PCM_PAD   = SLOT_W - PCM_W;
  localparam int TAG_GAP   = TAG_W - 1 - NUM_SLOTS - ID_W;

  logic                  is_write;
  logic [NUM_SLOTS-1:0]  flags;      // MSB flags slot 1
  logic [TAG_W-1:0]      tag;
  logic [SLOT_W-1:0]     slot_w [NUM_SLOTS];

  assign is_write = cmd_on && !cmd_read;

  always_comb begin
    flags                = '0;
    flags[NUM_SLOTS-1]   = cmd_on;
    flags[NUM_SLOTS-2]   = is_write;
    flags[NUM_SLOTS-3]   = play;
    flags[NUM_SLOTS-4]   = play;
  end

  assign tag = {cmd_on | play, flags, {TAG_GAP{1'b0}}, codec_id};

  // Slot k of the link sits at array index k-1.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (s == 0) begin : g_addr
      assign slot_w[s] = cmd_on ? {cmd_read, cmd_index, {CMD_PAD{1'b0}}} : '0;
    end else if (s == 1) begin : g_wdat
      assign slot_w[s] = is_write ? {cmd_wdata, {DATA_PAD{1'b0}}} : '0;
    end else if (s == 2) begin : g_left
      assign slot_w[s] = play ? {left, {PCM_PAD{1'b0}}} : '0;
    end else if (s == 3) begin : g_right
      assign slot_w[s] = play ? {right, {PCM_PAD{1'b0}}} : '0;
    end else begin : g_zero
      assign slot_w[s] = '0;
    end
  end

  always_comb begin
    frame = '0;
    frame[FRAME_LEN-1 -: TAG_W] = tag;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      frame[FRAME_LEN-TAG_W-1-s*SLOT_W -: SLOT_W] = slot_w[s];
    end
  end

endmodule

// File: rtl/aclink_shifter.sv
// Parallel-load, MSB-first shift register with a registered data pin.
module aclink_shifter #(
  parameter int FRAME_LEN = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [FRAME_LEN-1:0] frame,
  output logic                 sdata
);

  logic [FRAME_LEN-1:0] sh_q;
  logic                 sd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      sd_q <= 1'b0;
    end else if (load) begin
      sd_q <= frame[FRAME_LEN-1];
      sh_q <= {frame[FRAME_LEN-2:0], 1'b0};
    end else begin
      sd_q <= sh_q[FRAME_LEN-1];
      sh_q <= {sh_q[FRAME_LEN-2:0], 1'b0};
    end
  end

  assign sdata = sd_q;

endmodule

// File: rtl/aclink_tx_serializer.sv
// Outgoing link frame serializer: timer, command holder, frame builder, shifter.
module aclink_tx_serializer #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int IDX_W     = 7,
  parameter int DATA_W    = 16,
  parameter int PCM_W     = 16,
  parameter int ID_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   codec_id,
  input  logic              play_en,
  input  logic [PCM_W-1:0]  pcm_left,
  input  logic [PCM_W-1:0]  pcm_right,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              rsp_done,
  output logic              cmd_busy,
  output logic              cmd_sent,
  output logic              sdata,
  output logic              sync
);

  localparam int FRAME_LEN = TAG_W + NUM_SLOTS * SLOT_W;

  logic                  load;
  logic                  last;
  logic                  sync_nxt;
  logic                  sync_q;
  logic                  cmd_on;
  logic                  hold_read;
  logic [IDX_W-1:0]      hold_index;
  logic [DATA_W-1:0]     hold_wdata;
  logic [FRAME_LEN-1:0]  frame;

  aclink_bit_timer #(
    .FRAME_LEN (FRAME_LEN),
    .SYNC_W    (TAG_W)
  ) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .last     (last),
    .sync_nxt (sync_nxt)
  );

  aclink_cmd_tracker #(
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) i_cmd (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_read   (cmd_read),
    .cmd_index  (cmd_index),
    .cmd_wdata  (cmd_wdata),
    .rsp_done   (rsp_done),
    .load       (load),
    .last       (last),
    .cmd_on     (cmd_on),
    .hold_read  (hold_read),
    .hold_index (hold_index),
    .hold_wdata (hold_wdata),
    .busy       (cmd_busy),
    .sent       (cmd_sent)
  );

  aclink_frame_builder #(
    .TAG_W     (TAG_W),
    .SLOT_W    (SLOT_W),
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W),
    .DATA_W    (DATA_W),
    .PCM_W     (PCM_W),
    .ID_W      (ID_W)
  ) i_build (
    .cmd_on    (cmd_on),
    .cmd_read  (hold_read),
    .cmd_index (hold_index),
    .cmd_wdata (hold_wdata),
    .play      (play_en),
    .left      (pcm_left),
    .right     (pcm_right),
    .codec_id  (codec_id),
    .frame     (frame)
  );

  aclink_shifter #(
    .FRAME_LEN (FRAME_LEN)
  ) i_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .frame (frame),
    .sdata (sdata)
  );

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 1'b0;
    else     sync_q <= sync_nxt;
  end

  assign sync = sync_q;

endmodule

// File: rtl/aclink_tx_chk.sv
// Port-level timing checks for the outgoing link serializer.
module aclink_tx_chk #(
  parameter int FRAME_LEN = 256,
  parameter int TAG_W     = 16
) (
  input logic clk,
  input logic rst,
  input logic sync,
  input logic cmd_sent,
  input logic cmd_busy,
  input logic cmd_valid,
  input logic rsp_done
);

  localparam int GW = $clog2(FRAME_LEN) + 1;

  logic          sync_d;
  logic          seen_q;
  logic [GW-1:0] gap_q;
  logic          rise;

  assign rise = sync && !sync_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_d <= 1'b0;
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      sync_d <= sync;
      if (rise) begin
        seen_q <= 1'b1;
        gap_q  <= GW'(1);
      end else if (gap_q != '1) begin
        gap_q  <= gap_q + 1'b1;
      end
    end
  end

  // R1: consecutive sync rises are exactly one frame apart
  p_frame_period_r1: assert property (@(posedge clk) disable iff (rst)
    (rise && seen_q) |-> (gap_q == GW'(FRAME_LEN)));

  // R2: sync stays high for the tag width counted from its rise
  p_sync_width_r2: assert property (@(posedge clk) disable iff (rst)
    (!rise && seen_q) |-> (sync == (gap_q < GW'(TAG_W))));

  // R9: the sent marker lasts one cycle
  p_sent_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_sent |=> !cmd_sent);

  // R9: the sent marker coincides with the frame's last bit
  p_sent_at_end_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_sent |-> rise);

  // R10: busy covers the sent marker
  p_busy_on_sent_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_sent |-> cmd_busy);

  // R10: busy only drops on a reply
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_busy && !rsp_done) |=> cmd_busy);

  // R8: busy only rises on a request
  p_busy_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (!cmd_busy && !cmd_valid) |=> !cmd_busy);

endmodule

bind aclink_tx_serializer aclink_tx_chk #(
  .FRAME_LEN (TAG_W + NUM_SLOTS * SLOT_W),
  .TAG_W     (TAG_W)
) i_aclink_tx_chk (
  .clk       (clk),
  .rst       (rst),
  .sync      (sync),
  .cmd_sent  (cmd_sent),
  .cmd_busy  (cmd_busy),
  .cmd_valid (cmd_valid),
  .rsp_done  (rsp_done)
);

// File: tb/test_aclink_tx_serializer.sv
module test_aclink_tx_serializer;

  localparam int CLK_PERIOD = 10;
  localparam int FL         = 256;
  localparam int NV         = 6;

  typedef struct packed {
    logic        play;
    logic [15:0] l;
    logic [15:0] r;
    logic        cmd;
    logic        rd;
    logic [6:0]  idx;
    logic [15:0] wd;
    logic [1:0]  cid;
    logic [15:0] tag;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 7'h00, 16'h0000, 2'd0, 16'h0000},
    '{1'b1, 16'h1234, 16'hABCD, 1'b0, 1'b0, 7'h00, 16'h0000, 2'd1, 16'h9801},
    '{1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 7'h02, 16'h8080, 2'd0, 16'hE000},
    '{1'b1, 16'hFFFF, 16'h0001, 1'b1, 1'b1, 7'h7C, 16'h0000, 2'd3, 16'hD803},
    '{1'b1, 16'h8001, 16'h7FFE, 1'b1, 1'b0, 7'h7F, 16'hFFFF, 2'd2, 16'hF802},
    '{1'b0, 16'h5555, 16'hAAAA, 1'b0, 1'b0, 7'h00, 16'h0000, 2'd2, 16'h0002}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  codec_id = '0;
  logic        play_en = 1'b0;
  logic [15:0] pcm_left = '0;
  logic [15:0] pcm_right = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_read = 1'b0;
  logic [6:0]  cmd_index = '0;
  logic [15:0] cmd_wdata = '0;
  logic        rsp_done = 1'b0;
  logic        cmd_busy;
  logic        cmd_sent;
  logic        sdata;
  logic        sync;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aclink_tx_serializer i_aclink_tx_serializer (
    .clk       (clk),
    .rst       (rst),
    .codec_id  (codec_id),
    .play_en   (play_en),
    .pcm_left  (pcm_left),
    .pcm_right (pcm_right),
    .cmd_valid (cmd_valid),
    .cmd_read  (cmd_read),
    .cmd_index (cmd_index),
    .cmd_wdata (cmd_wdata),
    .rsp_done  (rsp_done),
    .cmd_busy  (cmd_busy),
    .cmd_sent  (cmd_sent),
    .sdata     (sdata),
    .sync      (sync)
  );

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] exp_frame(vec_t v);
    logic [15:0] tag;
    logic [19:0] s1, s2, s3, s4;
    tag = {v.play | v.cmd, v.cmd, v.cmd & ~v.rd, v.play, v.play, 8'h00, 1'b0, v.cid};
    s1  = v.cmd ? {v.rd, v.idx, 12'h000} : 20'h0;
    s2  = (v.cmd && !v.rd) ? {v.wd, 4'h0} : 20'h0;
    s3  = v.play ? {v.l, 4'h0} : 20'h0;
    s4  = v.play ? {v.r, 4'h0} : 20'h0;
    return {tag, s1, s2, s3, s4, 160'h0};
  endfunction

  task automatic wait_rise();
    logic p;
    p = sync;
    forever begin
      @(negedge clk);
      if (sync && !p) break;
      p = sync;
    end
  endtask

  task automatic wait_fall();
    logic p;
    p = sync;
    forever begin
      @(negedge clk);
      if (!sync && p) break;
      p = sync;
    end
  endtask

  // Collects the 256 bits that follow a sync rise sample.
  task automatic grab(output logic [255:0] f, output logic sync_ok,
                      output logic sent_end, output logic sent_mid);
    sync_ok  = 1'b1;
    sent_end = 1'b0;
    sent_mid = 1'b0;
    for (int b = 0; b < FL; b++) begin
      @(negedge clk);
      f[FL-1-b] = sdata;
      if (sync !== ((b < 15) || (b == FL-1))) sync_ok = 1'b0;
      if (b == FL-1) sent_end = cmd_sent;
      else if (cmd_sent) sent_mid = 1'b1;
    end
  endtask

  task automatic issue(logic rd, logic [6:0] idx, logic [15:0] wd);
    @(negedge clk);
    cmd_read  = rd;
    cmd_index = idx;
    cmd_wdata = wd;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic reply();
    @(negedge clk);
    rsp_done = 1'b1;
    @(negedge clk);
    rsp_done = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [255:0] f;
    logic [255:0] g;
    logic         s_ok, s_end, s_mid;
    vec_t         v;

    repeat (3) @(negedge clk);
    // R11: outputs quiet while reset is held
    chk("R11 reset outputs", {252'h0, sdata, sync, cmd_busy, cmd_sent}, 256'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 sync rises on first clock", {255'h0, sync}, 256'h1);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      @(negedge clk);
      play_en   = v.play;
      pcm_left  = v.l;
      pcm_right = v.r;
      codec_id  = v.cid;
      if (v.cmd) begin
        wait_fall();
        issue(v.rd, v.idx, v.wd);
      end
      wait_rise();
      grab(f, s_ok, s_end, s_mid);
      g = exp_frame(v);
      chk("R3 tag word", {240'h0, f[255:240]}, {240'h0, v.tag});
      chk("R4 slot1", {236'h0, f[239:220]}, {236'h0, g[239:220]});
      chk("R5 slot2", {236'h0, f[219:200]}, {236'h0, g[219:200]});
      chk("R6 slots 3 and 4", {216'h0, f[199:160]}, {216'h0, g[199:160]});
      chk("R7 slots 5 to 12", {96'h0, f[159:0]}, 256'h0);
      chk("R1 whole frame", f, g);
      chk("R2 sync pattern", {255'h0, s_ok}, 256'h1);
      chk("R9 cmd_sent at frame end", {254'h0, s_mid, s_end}, {254'h0, 1'b0, v.cmd});
      if (v.cmd) begin
        chk("R10 busy after send", {255'h0, cmd_busy}, 256'h1);
        reply();
        chk("R10 busy released", {255'h0, cmd_busy}, 256'h0);
      end
    end

    // R8: sent once, absent from the following frame
    play_en = 1'b0;
    codec_id = 2'd0;
    wait_fall();
    issue(1'b0, 7'h15, 16'h00F0);
    wait_rise();
    grab(f, s_ok, s_end, s_mid);
    chk("R8 command in first frame", {236'h0, f[239:220]}, {236'h0, 1'b0, 7'h15, 12'h000});
    grab(f, s_ok, s_end, s_mid);
    chk("R8 command not repeated", {236'h0, f[255:254], f[239:220]}, 256'h0);
    chk("R9 no second cmd_sent", {254'h0, s_mid, s_end}, 256'h0);

    // R10: request while busy is dropped
    issue(1'b1, 7'h11, 16'h0000);
    wait_rise();
    grab(f, s_ok, s_end, s_mid);
    chk("R10 refused command absent", {236'h0, f[239:220]}, 256'h0);
    chk("R10 still busy", {255'h0, cmd_busy}, 256'h1);
    reply();
    chk("R10 released after reply", {255'h0, cmd_busy}, 256'h0);

    // R10: early reply while pending is ignored
    wait_fall();
    issue(1'b1, 7'h22, 16'h0000);
    reply();
    chk("R10 early reply ignored", {255'h0, cmd_busy}, 256'h1);
    wait_rise();
    grab(f, s_ok, s_end, s_mid);
    chk("R8 command after early reply", {236'h0, f[239:220]}, {236'h0, 1'b1, 7'h22, 12'h000});
    chk("R9 sent after early reply", {255'h0, s_end}, 256'h1);
    chk("R10 busy until real reply", {255'h0, cmd_busy}, 256'h1);

    // R11: reset in mid-frame
    wait_fall();
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R11 mid-frame reset", {252'h0, sdata, sync, cmd_busy, cmd_sent}, 256'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 sync after mid-frame reset", {255'h0, sync}, 256'h1);

    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule